// File: doc/BRIEF.md
# Variable-Width Transmit Queue Front End

This block sits between a register write bus and the byte-level shifter of a serial flash controller. Software writes a 32-bit word to one of four transmit addresses. The address selects how many bytes of that word enter a byte-wide transmit queue: four, one, two or three. The bytes are always taken from the low end of the word, least significant byte first. The shifter pulls bytes from the queue with a valid/ready handshake.

Each accepted write also leaves its byte count in a small side queue. The shifter returns one received byte for every byte it sends. The block collects those bytes back into words of the same width as the write that caused them, so software reads the replies of a one-, two-, three- or four-byte write as a single word. If the queue cannot take all the bytes of a write, the write is refused as a whole and a sticky flag records the loss.

Top module: `vwq_txq`

## Requirements
- R1: A write with `wr_sel` = 0 enqueues four bytes, `wr_data[7:0]` first and `wr_data[31:24]` last.
- R2: A write with `wr_sel` = 1 enqueues only `wr_data[7:0]`.
- R3: A write with `wr_sel` = 2 enqueues `wr_data[7:0]` and then `wr_data[15:8]`.
- R4: A write with `wr_sel` = 3 enqueues `wr_data[7:0]`, `wr_data[15:8]` and then `wr_data[23:16]`.
- R5: Bytes leave on `tx_byte` in the order they were enqueued. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_byte` hold their values.
- R6: Received bytes are grouped by the byte count of the oldest pending write. The first byte of a group lands in `rx_word[7:0]`, the next in `[15:8]`, and so on. When a group is complete, `rx_word_valid` pulses for one cycle and `rx_word_bytes` (1 to 4) gives the group size.
- R7: In a word with fewer than four bytes, every byte lane above `rx_word_bytes` reads as zero.
- R8: A write whose byte count exceeds the free space, DEPTH minus `tx_level`, enqueues nothing and sets `overflow`.
- R9: A write that arrives while WDEPTH writes are still waiting for their received bytes enqueues nothing and sets `overflow`, even if byte space remains.
- R10: `overflow` stays set until reset.
- R11: A received byte that arrives while no write is waiting for replies is discarded and does not affect later words.
- R12: After reset, `tx_valid`, `rx_word_valid`, `overflow` and `tx_full` are 0, `tx_level` is 0 and `tx_empty` is 1.
- R13: `tx_level` counts the bytes that have been accepted but not yet moved into the output stage behind `tx_byte`. `tx_full` is set exactly when `tx_level` equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe of the register bus |
| wr_sel | input | 2 | Transmit address select; sets the byte count |
| wr_data | input | 32 | Write word |
| tx_ready | input | 1 | Shifter accepts `tx_byte` |
| tx_valid | output | 1 | `tx_byte` holds a byte to send |
| tx_byte | output | 8 | Next byte to send |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_word_valid | output | 1 | One-cycle pulse: `rx_word` is complete |
| rx_word | output | 32 | Packed received word, right-aligned |
| rx_word_bytes | output | 3 | Number of valid bytes in `rx_word` |
| tx_level | output | $clog2(DEPTH)+1 | Bytes stored and not yet staged |
| tx_full | output | 1 | Byte store is full |
| tx_empty | output | 1 | No byte stored or staged |
| overflow | output | 1 | Sticky: a write was refused |

## Verification
The bench sweeps all four write addresses over several data patterns, with the shifter ready every cycle and then every other cycle. A lane offset error in the banked store would send bytes out of order or repeat them, and a wrong count would leave extra bytes or drop the top ones. It fills the store until one byte remains free, then shows that a two-byte write is refused in full while a one-byte write still fits. A design that wrote part of the refused word would send stray bytes during the drain. It fills the width queue with one-byte writes so that the width queue, not the byte store, refuses the next write. It also injects a received byte while nothing is pending; a packer that kept it would return a shifted word for the next one-byte write.

// File: rtl/vwq_pkg.sv
package vwq_pkg;

  // Write address select: the code fixes how many bytes are enqueued.
  typedef enum logic [1:0] {
    SEL_FOUR  = 2'd0,
    SEL_ONE   = 2'd1,
    SEL_TWO   = 2'd2,
    SEL_THREE = 2'd3
  } wsel_e;

  // Byte count carried by a select code (1..4).
  function automatic logic [2:0] sel_bytes(input logic [1:0] sel);
    return (sel == SEL_FOUR) ? 3'd4 : {1'b0, sel};
  endfunction

endpackage

// File: rtl/vwq_tx_store.sv
// Banked byte store: up to four bytes in per cycle, one byte out per cycle.
// Byte with absolute index p lives in bank p[1:0] at row p[AW-1:2], so a
// multi-byte write touches each bank at most once.
module vwq_tx_store #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [2:0]               push_n,
  input  logic [31:0]              push_data,
  input  logic                     tx_ready,
  output logic                     tx_valid,
  output logic [7:0]               tx_byte,
  output logic [$clog2(DEPTH):0]   level
);
  localparam int AW    = $clog2(DEPTH);
  localparam int ROWS  = DEPTH / 4;
  localparam int LANES = 4;

  logic [AW:0] wptr, rptr;
  logic [7:0]  bank_rd [LANES];
  logic        load;

  assign level = wptr - rptr;
  assign load  = (level != '0) && (!tx_valid || tx_ready);

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    localparam logic [1:0] LANE = 2'(b);
    logic [7:0]    mem [ROWS];
    logic [1:0]    off;
    logic [AW:0]   pos;
    logic          we;
    logic [7:0]    wd;

    assign off = LANE - wptr[1:0];
    assign pos = wptr + {{(AW - 1){1'b0}}, off};
    assign we  = push && ({1'b0, off} < push_n);
    assign wd  = push_data[{off, 3'b000} +: 8];

    always_ff @(posedge clk) begin
      if (we) mem[pos[AW-1:2]] <= wd;
    end

    assign bank_rd[b] = mem[rptr[AW-1:2]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      if (push) wptr <= wptr + {{(AW - 2){1'b0}}, push_n};
      if (load) begin
        tx_byte  <= bank_rd[rptr[1:0]];
        tx_valid <= 1'b1;
        rptr     <= rptr + 1'b1;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vwq_width_q.sv
// Side queue of select codes, one entry per accepted write.
module vwq_width_q #(
  parameter int WDEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic [1:0] push_code,
  input  logic       pop,
  output logic       head_valid,
  output logic [2:0] head_bytes,
  output logic       full
);
  import vwq_pkg::*;
  localparam int AW = $clog2(WDEPTH);

  logic [1:0]  mem [WDEPTH];
  logic [AW:0] wptr, rptr, count;

  assign count      = wptr - rptr;
  assign full       = (count == (AW + 1)'(WDEPTH));
  assign head_valid = (count != '0);
  assign head_bytes = sel_bytes(mem[rptr[AW-1:0]]);

  always_ff @(posedge clk) begin
    if (push) mem[wptr[AW-1:0]] <= push_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
    end
  end

endmodule

// File: rtl/vwq_rx_pack.sv
// Gathers received bytes, least significant lane first, into a word whose
// size is the head entry of the width queue.
module vwq_rx_pack (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        head_valid,
  input  logic [2:0]  head_bytes,
  output logic        pop,
  output logic        rx_word_valid,
  output logic [31:0] rx_word,
  output logic [2:0]  rx_word_bytes
);
  logic [1:0]  lane_cnt;
  logic [31:0] acc, merged;
  logic        take;

  assign take   = rx_valid && head_valid;
  assign pop    = take && (({1'b0, lane_cnt} + 3'd1) == head_bytes);
  assign merged = acc | ({24'h0, rx_byte} << {lane_cnt, 3'b000});

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_cnt      <= '0;
      acc           <= '0;
      rx_word       <= '0;
      rx_word_bytes <= '0;
      rx_word_valid <= 1'b0;
    end else begin
      rx_word_valid <= 1'b0;
      if (pop) begin
        rx_word       <= merged;
        rx_word_bytes <= head_bytes;
        rx_word_valid <= 1'b1;
        acc           <= '0;
        lane_cnt      <= '0;
      end else if (take) begin
        acc      <= merged;
        lane_cnt <= lane_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vwq_txq.sv
// Top: admission control over the byte store and the width side queue.
module vwq_txq #(
  parameter int DEPTH  = 16,
  parameter int WDEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [31:0]              wr_data,
  input  logic                     tx_ready,
  output logic                     tx_valid,
  output logic [7:0]               tx_byte,
  input  logic                     rx_valid,
  input  logic [7:0]               rx_byte,
  output logic                     rx_word_valid,
  output logic [31:0]              rx_word,
  output logic [2:0]               rx_word_bytes,
  output logic [$clog2(DEPTH):0]   tx_level,
  output logic                     tx_full,
  output logic                     tx_empty,
  output logic                     overflow
);
  import vwq_pkg::*;
  localparam int LW = $clog2(DEPTH) + 1;

  logic [2:0]  nbytes;
  logic [LW:0] need;
  logic        fits, accept, wq_full, head_valid, rx_pop;
  logic [2:0]  head_bytes;

  assign nbytes = sel_bytes(wr_sel);
  assign need   = {1'b0, tx_level} + {{(LW - 2){1'b0}}, nbytes};
  assign fits   = (need <= (LW + 1)'(DEPTH)) && !wq_full;
  assign accept = wr_en && fits;

  assign tx_full  = (tx_level == LW'(DEPTH));
  assign tx_empty = (tx_level == '0) && !tx_valid;

  always_ff @(posedge clk) begin
    if (rst)                 overflow <= 1'b0;
    else if (wr_en && !fits) overflow <= 1'b1;
  end

  vwq_tx_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst),
    .push(accept), .push_n(nbytes), .push_data(wr_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .level(tx_level)
  );

  vwq_width_q #(.WDEPTH(WDEPTH)) wq_i (
    .clk(clk), .rst(rst),
    .push(accept), .push_code(wr_sel), .pop(rx_pop),
    .head_valid(head_valid), .head_bytes(head_bytes), .full(wq_full)
  );

  vwq_rx_pack pack_i (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .head_valid(head_valid), .head_bytes(head_bytes), .pop(rx_pop),
    .rx_word_valid(rx_word_valid), .rx_word(rx_word),
    .rx_word_bytes(rx_word_bytes)
  );

endmodule

// File: rtl/vwq_txq_chk.sv
module vwq_txq_chk #(
  parameter int DEPTH  = 16,
  parameter int WDEPTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [1:0]             wr_sel,
  input logic                   tx_ready,
  input logic                   tx_valid,
  input logic [7:0]             tx_byte,
  input logic                   rx_word_valid,
  input logic [31:0]            rx_word,
  input logic [2:0]             rx_word_bytes,
  input logic [$clog2(DEPTH):0] tx_level,
  input logic                   tx_full,
  input logic                   overflow
);
  import vwq_pkg::*;

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // R6
  word_size_chk: assert property (@(posedge clk) disable iff (rst)
    rx_word_valid |-> (rx_word_bytes >= 3'd1 && rx_word_bytes <= 3'd4));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_word_valid && rx_word_bytes < 3'd4) |->
      ((rx_word >> {rx_word_bytes, 3'b000}) == 32'h0));

  // R8
  no_room_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(tx_level) + int'(sel_bytes(wr_sel)) > DEPTH))
      |=> (overflow && tx_level <= $past(tx_level)));

  // R10
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R13
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_level) <= DEPTH) && (tx_full == (int'(tx_level) == DEPTH)));

endmodule

bind vwq_txq vwq_txq_chk #(.DEPTH(DEPTH), .WDEPTH(WDEPTH)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
  .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .rx_word_valid(rx_word_valid), .rx_word(rx_word),
  .rx_word_bytes(rx_word_bytes), .tx_level(tx_level),
  .tx_full(tx_full), .overflow(overflow)
);

// File: tb/vwq_txq_tb_top.sv
module vwq_txq_tb_top;
  localparam int DEPTH  = 16;
  localparam int WDEPTH = 16;
  localparam int LW     = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [31:0]   wr_data = '0;
  logic          tx_ready = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic          tx_valid, rx_word_valid, tx_full, tx_empty, overflow;
  logic [7:0]    tx_byte;
  logic [31:0]   rx_word;
  logic [2:0]    rx_word_bytes;
  logic [LW-1:0] tx_level;

  always #5 clk = ~clk;

  vwq_txq #(.DEPTH(DEPTH), .WDEPTH(WDEPTH)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_word_valid(rx_word_valid), .rx_word(rx_word),
    .rx_word_bytes(rx_word_bytes), .tx_level(tx_level),
    .tx_full(tx_full), .tx_empty(tx_empty), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Expected streams
  logic [7:0]  exp_tx  [512];
  logic [1:0]  exp_tsel[512];
  logic [31:0] exp_w   [256];
  logic [2:0]  exp_n   [256];
  int txn = 0, txi = 0, rxn = 0, rxi = 0;

  int ready_mode = 0;  // 0 hold, 1 always, 2 every other cycle
  bit stray = 1'b0;
  int cyc = 0;

  function automatic string sel_tag(input logic [1:0] s);
    case (s)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 4 : int'(s);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Shifter model: loops each sent byte back, XOR A5, in the same cycle.
  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      1: tx_ready = 1'b1;
      2: tx_ready = cyc[0];
      default: tx_ready = 1'b0;
    endcase
    rx_valid = 1'b0;
    if (tx_valid && tx_ready) begin
      if (txi < txn)
        chk(tx_byte == exp_tx[txi], sel_tag(exp_tsel[txi]), "tx byte (R5 order)",
            {24'h0, tx_byte}, {24'h0, exp_tx[txi]});
      else
        chk(1'b0, "R5", "unexpected tx byte", {24'h0, tx_byte}, 32'h0);
      txi++;
      rx_byte  = tx_byte ^ 8'hA5;
      rx_valid = 1'b1;
    end else if (stray) begin
      rx_byte  = 8'h3C;
      rx_valid = 1'b1;
    end
    if (rx_word_valid) begin
      if (rxi < rxn) begin
        chk(rx_word == exp_w[rxi], "R6", "rx word (R7 upper zero)",
            rx_word, exp_w[rxi]);
        chk(rx_word_bytes == exp_n[rxi], "R6", "rx word bytes",
            {29'h0, rx_word_bytes}, {29'h0, exp_n[rxi]});
      end else
        chk(1'b0, "R11", "unexpected rx word", rx_word, 32'h0);
      rxi++;
    end
  end

  task automatic do_write(input logic [1:0] s, input logic [31:0] d,
                          input bit accepted);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    if (accepted) begin
      logic [31:0] m;
      for (int k = 0; k < nb(s); k++) begin
        exp_tx[txn]   = d[8*k +: 8];
        exp_tsel[txn] = s;
        txn++;
      end
      m = (nb(s) == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb(s))) - 1);
      exp_w[rxn] = (d ^ 32'hA5A5_A5A5) & m;
      exp_n[rxn] = 3'(nb(s));
      rxn++;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int t = 0; t < 400 && !(txi == txn && rxi == rxn); t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(txi == txn && rxi == rxn, tag, "all expected words returned",
        32'(rxi), 32'(rxn));
  endtask

  task automatic set_mode(input int m);
    @(posedge clk);
    ready_mode = m;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    txn = 0; txi = 0; rxn = 0; rxi = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", txi, txn);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(!tx_valid, "R12", "tx_valid", {31'h0, tx_valid}, 32'h0);
    chk(!rx_word_valid, "R12", "rx_word_valid", {31'h0, rx_word_valid}, 32'h0);
    chk(!overflow, "R12", "overflow", {31'h0, overflow}, 32'h0);
    chk(tx_level == '0 && tx_empty && !tx_full, "R12", "level/empty/full",
        {27'h0, tx_level}, 32'h0);

    // R1..R4 sweep, two ready patterns
    for (int mode = 1; mode <= 2; mode++) begin
      set_mode(mode);
      for (int s = 0; s < 4; s++) begin
        for (int p = 0; p < 4; p++) begin
          logic [31:0] d;
          d = (32'h0102_0304 * (p + 1)) ^ {8'(s), 8'(p), 8'hF0, 8'(mode)};
          if (p == 3) d = 32'hFFFF_FFFF;
          do_write(2'(s), d, 1'b1);
          drain(sel_tag(2'(s)));
        end
      end
    end

    // R8 / R13: fill byte store with shifter stalled
    do_reset();
    set_mode(0);
    for (int k = 0; k < 4; k++) do_write(2'd0, 32'hA0B0C0D0 + 32'(k), 1'b1);
    chk(tx_level == LW'(15), "R13", "level after 16 bytes, one staged",
        {27'h0, tx_level}, 32'd15);
    chk(tx_valid && tx_byte == 8'hD0, "R5", "first byte held while stalled",
        {24'h0, tx_byte}, 32'hD0);
    do_write(2'd2, 32'h0000_1111, 1'b0);
    chk(overflow, "R8", "two-byte write refused", {31'h0, overflow}, 32'h1);
    chk(tx_level == LW'(15), "R8", "level unchanged by refused write",
        {27'h0, tx_level}, 32'd15);
    do_write(2'd1, 32'h0000_0077, 1'b1);
    chk(tx_full && tx_level == LW'(16), "R13", "full at DEPTH",
        {27'h0, tx_level}, 32'd16);
    do_write(2'd1, 32'h0000_0088, 1'b0);
    set_mode(1);
    drain("R8");
    chk(overflow, "R10", "overflow sticky after drain", {31'h0, overflow}, 32'h1);
    chk(tx_empty && tx_level == '0, "R13", "empty after drain",
        {27'h0, tx_level}, 32'h0);

    // R9: width queue limit
    do_reset();
    chk(!overflow, "R12", "overflow cleared by reset", {31'h0, overflow}, 32'h0);
    set_mode(0);
    for (int k = 0; k < WDEPTH; k++) do_write(2'd1, 32'h0000_0040 + 32'(k), 1'b1);
    chk(!overflow && tx_level == LW'(WDEPTH - 1), "R9", "no refusal yet",
        {27'h0, tx_level}, 32'(WDEPTH - 1));
    do_write(2'd1, 32'h0000_0099, 1'b0);
    chk(overflow, "R9", "refused by width queue", {31'h0, overflow}, 32'h1);
    chk(tx_level == LW'(WDEPTH - 1), "R9", "no byte stored",
        {27'h0, tx_level}, 32'(WDEPTH - 1));
    set_mode(1);
    drain("R9");

    // R11: stray received byte with nothing pending
    @(posedge clk);
    stray = 1'b1;
    @(posedge clk);
    stray = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rx_word_valid, "R11", "no word from stray byte",
        {31'h0, rx_word_valid}, 32'h0);
    do_write(2'd1, 32'h1234_5601, 1'b1);
    do_write(2'd2, 32'h1234_5602, 1'b1);
    drain("R11");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule